// File: doc/BRIEF.md
# Timer trigger and event routing

This block is the control-driven routing stage inside a general-purpose timer. It takes the timer's internal signals and forms three results. The first is one trigger line for cascaded timers, chosen from eight internal sources. The second is one DMA request per capture/compare channel. The third is the first timer input, taken from the channel pins. It also produces a periodic sampling strobe. The dead-time generator and the input filters use this strobe as their clock enable. The counter, the compare units, the filters and the dead-time logic all sit outside this block.

A single 7-bit configuration word holds every setting. It is written through `cfg_we`/`cfg_wdata`. Each DMA channel runs its own two-state machine. In `DQ_IDLE`, a qualifying event takes the transition *fire* to `DQ_PEND`. In `DQ_PEND`, a high acknowledge takes the transition *ack* back to `DQ_IDLE`. In any other case each state holds, through the transitions *wait* (idle) and *hold* (pending). The sampling divider has three settings: a period of 1, 2 or 4 clock cycles. It restarts its count whenever the divide setting changes.

Top module: `tmr_route`

## Requirements
- R1: Configuration word bits [2:0] select the trigger source, bit 3 selects DMA-on-update, bit 4 selects XOR input mode, and bits [6:5] hold the divide code. The word is captured at the clock edge where `cfg_we` is high, and every field is zero after reset.
- R2: Directly after reset, `trg_out` and all `dma_req` bits are low, `smp_en` is high on every cycle, and `ti1` follows `ch_pin[0]`.
- R3: With trigger source 0, 1 or 2, `trg_out` in the cycle after an edge equals `cnt_rst`, `cnt_en` or `upd_evt` respectively, as sampled at that edge.
- R4: With trigger source 3, `trg_out` is high in the cycle after an edge exactly when some `cc_evt` bit was high at that edge.
- R5: With trigger sources 4 to 7, `trg_out` in the cycle after an edge equals `oc_ref[0]` to `oc_ref[3]` respectively, as sampled at that edge.
- R6: With bit 3 clear, `dma_req[i]` rises in the cycle after `cc_evt[i]` is high, and `upd_evt` raises no request.
- R7: With bit 3 set, every idle channel raises `dma_req` in the cycle after `upd_evt`, and `cc_evt` raises no request.
- R8: A raised `dma_req[i]` stays high until `dma_ack[i]` is seen at an edge, and falls in the next cycle. Events that arrive while it is pending leave no second request behind.
- R9: With bit 4 clear, `ti1` equals `ch_pin[0]`. With bit 4 set, it equals the XOR of `ch_pin[2:0]`. It follows the pins in the same cycle.
- R10: Divide codes 0, 1 and 2 give `smp_en` one high cycle in every 1, 2 or 4 cycles respectively. The reserved code 3 behaves as code 0.
- R11: When the divide code changes, the divider restarts. Counting the first cycle after the change takes effect as cycle 0, `smp_en` is high in cycles P-1, 2P-1 and so on, where P is the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration word |
| cnt_rst | input | 1 | Counter reset signal |
| cnt_en | input | 1 | Counter enable signal |
| upd_evt | input | 1 | Update event strobe |
| cc_evt | input | NCH | Per-channel capture/compare event strobes |
| oc_ref | input | 4 | Compare reference outputs 1 to 4 |
| ch_pin | input | 3 | Channel pins 1 to 3 |
| dma_ack | input | NCH | Per-channel DMA acknowledge |
| trg_out | output | 1 | Trigger output to slave timers |
| ti1 | output | 1 | First timer input |
| dma_req | output | NCH | Per-channel DMA requests |
| smp_en | output | 1 | Dead-time / filter sampling strobe |

## Verification
The bench builds the block with its default of four channels. With that setting every trigger code is swept against many mixes of source inputs. All eight pin combinations are tried in both input modes. Each channel's request state machine is walked through all of its transitions in both DMA modes, and all four divide codes are covered, including a restart in the middle of a period.

// File: rtl/tmr_route_pkg.sv
package tmr_route_pkg;

    typedef enum logic [2:0] {
        TRG_RST = 3'd0,
        TRG_EN  = 3'd1,
        TRG_UPD = 3'd2,
        TRG_CCP = 3'd3,
        TRG_OC1 = 3'd4,
        TRG_OC2 = 3'd5,
        TRG_OC3 = 3'd6,
        TRG_OC4 = 3'd7
    } trg_src_e;

    typedef enum logic [1:0] {
        SDIV_1   = 2'd0,
        SDIV_2   = 2'd1,
        SDIV_4   = 2'd2,
        SDIV_RSV = 2'd3
    } sdiv_e;

    typedef enum logic {
        DQ_IDLE = 1'b0,
        DQ_PEND = 1'b1
    } dreq_state_e;

    typedef struct packed {
        sdiv_e    sdiv;
        logic     ti1_xor;
        logic     dma_on_upd;
        trg_src_e trg_src;
    } route_cfg_t;

    localparam int CFG_W = $bits(route_cfg_t);
    localparam int NREF  = 4;

endpackage

// File: rtl/tmr_trg_mux.sv
module tmr_trg_mux
    import tmr_route_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  trg_src_e            src,
    input  logic                cnt_rst,
    input  logic                cnt_en,
    input  logic                upd_evt,
    input  logic [NCH-1:0]      cc_evt,
    input  logic [NREF-1:0]     oc_ref,
    output logic                trg_out
);

    logic trg_nxt;

    always_comb begin
        unique case (src)
            TRG_RST: trg_nxt = cnt_rst;
            TRG_EN:  trg_nxt = cnt_en;
            TRG_UPD: trg_nxt = upd_evt;
            TRG_CCP: trg_nxt = |cc_evt;
            TRG_OC1: trg_nxt = oc_ref[0];
            TRG_OC2: trg_nxt = oc_ref[1];
            TRG_OC3: trg_nxt = oc_ref[2];
            TRG_OC4: trg_nxt = oc_ref[3];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trg_out <= 1'b0;
        else        trg_out <= trg_nxt;
    end

    // R4: a capture/compare hit under the pulse source shows one cycle later
    a_r4_ccp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (src == TRG_CCP && |cc_evt) |=> trg_out);

    // R5: compare reference 1 appears on the trigger one cycle later
    a_r5_oc1_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (src == TRG_OC1) |=> (trg_out == $past(oc_ref[0])));

endmodule

// File: rtl/tmr_dma_fsm.sv
module tmr_dma_fsm
    import tmr_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic ack,
    output logic req
);

    dreq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DQ_IDLE: if (fire) state_d = DQ_PEND;
            DQ_PEND: if (ack)  state_d = DQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            DQ_IDLE: req = 1'b0;
            DQ_PEND: req = 1'b1;
        endcase
    end

    // R6: an event seen while idle raises the request next cycle
    a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && fire) |=> req);

    // R8: a pending request without acknowledge is held
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);

    // R8: an acknowledge drops a pending request
    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);

endmodule

// File: rtl/tmr_smp_div.sv
module tmr_smp_div
    import tmr_route_pkg::*;
#(
    parameter int MAX_DIV = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  sdiv_e sdiv,
    output logic  smp_en
);

    localparam int CNT_W = $clog2(MAX_DIV);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    sdiv_e            last_q;

    always_comb begin
        unique case (sdiv)
            SDIV_2:  lim = CNT_W'(1);
            SDIV_4:  lim = CNT_W'(3);
            default: lim = '0;
        endcase
    end

    assign smp_en = (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= SDIV_1;
        end else if (sdiv != last_q) begin
            cnt_q  <= '0;
            last_q <= sdiv;
        end else if (smp_en) begin
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R10: with a steady divide-by-4 setting, a strobe is never followed by another
    a_r10_div4_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && sdiv == SDIV_4 && last_q == SDIV_4) |=> (!smp_en || sdiv != SDIV_4));

    // R11: a code change restarts the count from zero
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (sdiv != last_q) |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_route.sv
module tmr_route
    import tmr_route_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [6:0]        cfg_wdata,
    input  logic              cnt_rst,
    input  logic              cnt_en,
    input  logic              upd_evt,
    input  logic [NCH-1:0]    cc_evt,
    input  logic [3:0]        oc_ref,
    input  logic [2:0]        ch_pin,
    input  logic [NCH-1:0]    dma_ack,
    output logic              trg_out,
    output logic              ti1,
    output logic [NCH-1:0]    dma_req,
    output logic              smp_en
);

    route_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= route_cfg_t'(cfg_wdata[CFG_W-1:0]);
    end

    assign ti1 = cfg_q.ti1_xor ? ^ch_pin : ch_pin[0];

    tmr_trg_mux #(.NCH(NCH)) u_trg (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (cfg_q.trg_src),
        .cnt_rst (cnt_rst),
        .cnt_en  (cnt_en),
        .upd_evt (upd_evt),
        .cc_evt  (cc_evt),
        .oc_ref  (oc_ref),
        .trg_out (trg_out)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_dma
        logic fire;
        assign fire = cfg_q.dma_on_upd ? upd_evt : cc_evt[g];

        tmr_dma_fsm u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (fire),
            .ack   (dma_ack[g]),
            .req   (dma_req[g])
        );
    end

    tmr_smp_div #(.MAX_DIV(4)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .sdiv   (cfg_q.sdiv),
        .smp_en (smp_en)
    );

    // R7: in update mode a channel event alone never raises a fresh request
    a_r7_no_cc_in_upd: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.dma_on_upd && !upd_evt && !cfg_we && dma_req == '0) |=> (dma_req == '0));

    // R2: reset clears every request and the trigger
    a_r2_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (dma_req == '0 && !trg_out));

endmodule

// File: tb/test_tmr_route.sv
module test_tmr_route;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cfg_we;
    logic [6:0]     cfg_wdata;
    logic           cnt_rst, cnt_en, upd_evt;
    logic [NCH-1:0] cc_evt;
    logic [3:0]     oc_ref;
    logic [2:0]     ch_pin;
    logic [NCH-1:0] dma_ack;
    logic           trg_out, ti1, smp_en;
    logic [NCH-1:0] dma_req;

    int errs = 0;
    int chks = 0;
    bit done = 0;

    tmr_route #(.NCH(NCH)) i_tmr_route (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cnt_rst(cnt_rst), .cnt_en(cnt_en), .upd_evt(upd_evt), .cc_evt(cc_evt),
        .oc_ref(oc_ref), .ch_pin(ch_pin), .dma_ack(dma_ack),
        .trg_out(trg_out), .ti1(ti1), .dma_req(dma_req), .smp_en(smp_en)
    );

    always #4 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [6:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        cnt_rst = 0; cnt_en = 0; upd_evt = 0; cc_evt = '0; oc_ref = '0;
        ch_pin = 3'b110; dma_ack = '0;
        tick(); tick();
        rst_n = 1'b1;
        #1;
        // R1 R2: reset state with all fields zero
        chk(trg_out == 1'b0, "R2 trg", trg_out, 0);
        chk(dma_req == '0, "R2 dma", dma_req, 0);
        chk(smp_en == 1'b1, "R2 smp", smp_en, 1);
        chk(ti1 == 1'b0, "R2 ti1", ti1, 0);
        ch_pin = 3'b001; #1;
        chk(ti1 == 1'b1, "R2 ti1", ti1, 1);

        // R3 R4 R5: sweep every trigger code against many input mixes
        for (int code = 0; code < 8; code++) begin
            wr_cfg(7'(code));
            for (int p = 0; p < 32; p++) begin
                logic [15:0] v;
                logic exp;
                v = 16'(p * 1237 + code * 311 + 5);
                cnt_rst = v[0]; cnt_en = v[1]; upd_evt = v[2];
                cc_evt = v[6:3]; oc_ref = v[10:7];
                case (code)
                    0: exp = v[0];
                    1: exp = v[1];
                    2: exp = v[2];
                    3: exp = |v[6:3];
                    default: exp = v[7 + code - 4];
                endcase
                tick();
                if (code < 3)       chk(trg_out == exp, "R3 trg", trg_out, exp);
                else if (code == 3) chk(trg_out == exp, "R4 trg", trg_out, exp);
                else                chk(trg_out == exp, "R5 trg", trg_out, exp);
            end
        end
        cnt_rst = 0; cnt_en = 0; upd_evt = 0; cc_evt = '0; oc_ref = '0;

        // R6 R8: channel-event mode, every channel
        wr_cfg(7'b0000000);
        dma_ack = '1; tick(); dma_ack = '0;
        chk(dma_req == '0, "R8 clear", dma_req, 0);
        for (int ch = 0; ch < NCH; ch++) begin
            cc_evt = NCH'(1 << ch); upd_evt = 1'b1;
            tick();
            chk(dma_req == NCH'(1 << ch), "R6 raise", dma_req, 1 << ch);
            cc_evt = '0; upd_evt = 1'b0;
            tick();
            chk(dma_req == NCH'(1 << ch), "R8 hold", dma_req, 1 << ch);
            cc_evt = NCH'(1 << ch);
            tick();
            cc_evt = '0;
            chk(dma_req == NCH'(1 << ch), "R8 repeat", dma_req, 1 << ch);
            dma_ack = NCH'(1 << ch);
            tick();
            dma_ack = '0;
            chk(dma_req == '0, "R8 ack", dma_req, 0);
            tick();
            chk(dma_req == '0, "R8 no queue", dma_req, 0);
        end
        upd_evt = 1'b1; tick(); upd_evt = 1'b0;
        chk(dma_req == '0, "R6 upd ignored", dma_req, 0);

        // R7: update mode
        wr_cfg(7'b0001000);
        cc_evt = '1; tick(); cc_evt = '0;
        chk(dma_req == '0, "R7 cc ignored", dma_req, 0);
        upd_evt = 1'b1; tick(); upd_evt = 1'b0;
        chk(dma_req == '1, "R7 raise", dma_req, 15);
        dma_ack = 4'b0101; tick(); dma_ack = '0;
        chk(dma_req == 4'b1010, "R8 partial ack", dma_req, 10);
        dma_ack = '1; tick(); dma_ack = '0;

        // R9: first input selection, all pin values
        for (int m = 0; m < 2; m++) begin
            wr_cfg(7'(m << 4));
            for (int pv = 0; pv < 8; pv++) begin
                logic e;
                ch_pin = 3'(pv); #1;
                e = m ? ((pv & 1) ^ ((pv >> 1) & 1) ^ ((pv >> 2) & 1)) : (pv & 1);
                chk(ti1 == e, "R9 ti1", ti1, e);
            end
        end

        // R10 R11: divide codes, each written as a change
        begin
            int seq [5] = '{2, 1, 3, 0, 2};
            for (int s = 0; s < 5; s++) begin
                int per;
                per = (seq[s] == 1) ? 2 : (seq[s] == 2) ? 4 : 1;
                wr_cfg(7'(seq[s] << 5));
                tick();
                for (int i = 0; i < 12; i++) begin
                    logic e;
                    e = ((i % per) == per - 1);
                    chk(smp_en == e, "R10 period", smp_en, e);
                    tick();
                end
            end
            // R11: restart in the middle of a period
            wr_cfg(7'(1 << 5));
            tick();
            wr_cfg(7'(2 << 5));
            tick();
            for (int i = 0; i < 8; i++) begin
                logic e;
                e = ((i % 4) == 3);
                chk(smp_en == e, "R11 restart", smp_en, e);
                tick();
            end
        end

        finish_run();
    end

endmodule